// File: doc/BRIEF.md
# Audio frame step generator

This block sets the slow timebase of a four-channel sound unit. It counts enabled machine cycles down from a reload value and, each time a countdown completes, moves an eight-position step index forward. With the default reload of 2048 and a machine-cycle enable of 1,048,576 Hz, the step rate is 512 Hz. On each step change it can fire one-cycle strobes for three consumers: the length counters, the frequency sweep and the volume envelopes. Which strobes fire depends on the step being left.

The current step index is an output. So is a flag that is high while the current step is one that does not clock length. Register-write logic uses that flag to decide whether a write that enables length counting should add an extra length clock.

Power is given as a level. A rising edge of that level is the power-on event. It restarts the sequence at step 0 with a fresh countdown. While power is low, the countdown and the step index freeze and no strobes are issued.

Top module: `aud_step_gen`

## Requirements
- R1: After reset, step_o is 0, all three strobes are low, extra_len_o is low, and the countdown holds its reload value.
- R2: After a reload, step_o changes on the clock edge that completes exactly CYCLES_PER_STEP cycles in which power_en and cyc_en are both high. Cycles with cyc_en low do not count.
- R3: len_stb_o pulses when the step being left is 0, 2, 4 or 6 (that is, step bit 0 is 0).
- R4: swp_stb_o pulses only when the step being left is 2 or 6.
- R5: env_stb_o pulses only when the step being left is 7.
- R6: step_o counts modulo 8. After 8 × CYCLES_PER_STEP enabled cycles from a reload it returns to 0.
- R7: Each strobe is registered. It is high for exactly one clock and appears on the same edge at which step_o takes its new value.
- R8: A rising edge of power_en sets step_o to 0 and reloads the countdown to CYCLES_PER_STEP on the next clock edge. No strobe is issued on that edge.
- R9: While power_en is low, the countdown and step_o hold their values and all strobes stay low, whatever cyc_en does.
- R10: extra_len_o is high exactly when step_o is odd (1, 3, 5 or 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en | input | 1 | Machine-cycle enable; one countdown decrement per high cycle |
| power_en | input | 1 | Sound unit power level; its rising edge restarts the sequence |
| len_stb_o | output | 1 | One-cycle length counter strobe |
| swp_stb_o | output | 1 | One-cycle frequency sweep strobe |
| env_stb_o | output | 1 | One-cycle volume envelope strobe |
| step_o | output | 3 | Current step index, 0 to 7 |
| extra_len_o | output | 1 | High while the current step does not clock length |

## Verification
The bench builds the block with CYCLES_PER_STEP set to 8 instead of 2048. A full eight-step cycle then takes 64 enabled cycles, so several wraps fit in a short run. These include wraps with a gapped enable, power-off holds in the middle of a countdown, and power-on restarts. The strobe pattern and the exact countdown boundary do not depend on the reload value, so the same corner cases are reached as with the default.

// File: rtl/aud_step_pkg.sv
package aud_step_pkg;

    localparam int STEP_COUNT = 8;
    localparam int STEP_W     = $clog2(STEP_COUNT);

    typedef struct packed {
        logic len;
        logic swp;
        logic env;
    } strobe_t;

endpackage

// File: rtl/aud_step_timer.sv
module aud_step_timer #(
    parameter int CYCLES_PER_STEP = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    input  logic power_en,
    output logic step_tick,
    output logic restart
);

    localparam int CNT_W = $clog2(CYCLES_PER_STEP + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CYCLES_PER_STEP);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pwr;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.pwr = power_en;
        restart   = power_en & ~tmr_q.pwr;
        step_tick = 1'b0;
        if (restart) begin
            tmr_d.cnt = RELOAD;
        end else if (power_en && cyc_en) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.cnt = RELOAD;
                step_tick = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt - LAST;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.cnt <= RELOAD;
            tmr_q.pwr <= 1'b0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R2: the countdown never leaves 1..RELOAD
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.cnt != '0) && (tmr_q.cnt <= RELOAD));

    // R9: power low freezes the countdown
    a_r9_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        !power_en |=> (tmr_q.cnt == $past(tmr_q.cnt)));

    // R8: power rising edge reloads the countdown
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (tmr_q.cnt == RELOAD));

endmodule

// File: rtl/aud_step_pattern.sv
module aud_step_pattern
    import aud_step_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    output strobe_t           strb,
    output logic              skip_len
);

    always_comb begin
        strb.len = ~step[0];
        strb.swp = (step[1:0] == 2'b10);
        strb.env = (step == STEP_W'(STEP_COUNT - 1));
        skip_len = step[0];
    end

endmodule

// File: rtl/aud_step_gen.sv
module aud_step_gen
    import aud_step_pkg::*;
#(
    parameter int CYCLES_PER_STEP = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              power_en,
    output logic              len_stb_o,
    output logic              swp_stb_o,
    output logic              env_stb_o,
    output logic [STEP_W-1:0] step_o,
    output logic              extra_len_o
);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        strobe_t           strb;
    } seq_t;

    seq_t    seq_d, seq_q;
    logic    tick, restart, skip_len;
    strobe_t pat;

    aud_step_timer #(.CYCLES_PER_STEP(CYCLES_PER_STEP)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_en   (cyc_en),
        .power_en (power_en),
        .step_tick(tick),
        .restart  (restart)
    );

    aud_step_pattern u_pattern (
        .step    (seq_q.step),
        .strb    (pat),
        .skip_len(skip_len)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.strb = '0;
        if (restart) begin
            seq_d.step = '0;
        end else if (tick) begin
            seq_d.strb = pat;
            seq_d.step = seq_q.step + STEP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign len_stb_o   = seq_q.strb.len;
    assign swp_stb_o   = seq_q.strb.swp;
    assign env_stb_o   = seq_q.strb.env;
    assign step_o      = seq_q.step;
    assign extra_len_o = skip_len;

    // R3: length strobe lands as an even step is left, so the new step is odd
    a_r3_len_even: assert property (@(posedge clk) disable iff (!rst_n)
        len_stb_o |-> step_o[0]);

    // R4: sweep strobe only after steps 2 and 6
    a_r4_swp_steps: assert property (@(posedge clk) disable iff (!rst_n)
        swp_stb_o |-> (step_o == 3'd3 || step_o == 3'd7));

    // R5: envelope strobe only after step 7
    a_r5_env_step: assert property (@(posedge clk) disable iff (!rst_n)
        env_stb_o |-> (step_o == 3'd0));

    // R7: strobes last one clock
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (len_stb_o || swp_stb_o || env_stb_o) |=> !(len_stb_o || swp_stb_o || env_stb_o));

    // R2: the step index moves only on a completed countdown or a restart
    a_r2_step_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(step_o));

    // R8: power-on forces step 0 with no strobe
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (step_o == '0 && !len_stb_o && !swp_stb_o && !env_stb_o));

endmodule

// File: tb/sim_aud_step_gen.sv
module sim_aud_step_gen;

    localparam int C = 8;

    typedef struct packed {
        logic [2:0] step;
        logic       len;
        logic       swp;
        logic       env;
        logic       flag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0;
    logic       power_en = 1'b0;
    logic       len_stb_o, swp_stb_o, env_stb_o, extra_len_o;
    logic [2:0] step_o;

    int total = 0;
    int bad = 0;
    exp_t q[$];

    int       m_cnt = C;
    int       m_step = 0;
    logic     m_prev = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    always #4 clk = ~clk;

    aud_step_gen #(.CYCLES_PER_STEP(C)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_en     (cyc_en),
        .power_en   (power_en),
        .len_stb_o  (len_stb_o),
        .swp_stb_o  (swp_stb_o),
        .env_stb_o  (env_stb_o),
        .step_o     (step_o),
        .extra_len_o(extra_len_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // driver: one cycle of stimulus plus the expected outputs after the next edge
    task automatic drive(input logic en, input logic pwr);
        exp_t e;
        @(negedge clk);
        cyc_en   = en;
        power_en = pwr;
        e = '0;
        if (pwr && !m_prev) begin
            m_step = 0;
            m_cnt  = C;
        end else if (pwr && en) begin
            if (m_cnt == 1) begin
                m_cnt = C;
                e.len = (m_step % 2) == 0;
                e.swp = (m_step == 2) || (m_step == 6);
                e.env = (m_step == 7);
                m_step = (m_step + 1) % 8;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
        m_prev = pwr;
        e.step = 3'(m_step);
        e.flag = (m_step % 2) == 1;
        q.push_back(e);
    endtask

    task automatic run(input int n, input logic en, input logic pwr);
        for (int i = 0; i < n; i++) drive(en, pwr);
    endtask

    task automatic drain();
        wait (q.size() == 0);
        #1;
    endtask

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() != 0) begin
                e = q.pop_front();
                check("R2 R6 step", int'(step_o), int'(e.step));
                check("R3 R7 len strobe", int'(len_stb_o), int'(e.len));
                check("R4 R7 sweep strobe", int'(swp_stb_o), int'(e.swp));
                check("R5 R7 envelope strobe", int'(env_stb_o), int'(e.env));
                check("R10 extra flag", int'(extra_len_o), int'(e.flag));
            end
        end
    end

    // watchdog
    initial begin
        #(200000 * 8);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset step", int'(step_o), 0);
        check("R1 reset strobes", int'({len_stb_o, swp_stb_o, env_stb_o}), 0);
        check("R1 reset flag", int'(extra_len_o), 0);
        rst_n = 1'b1;

        // power up, two full wraps with continuous enable
        run(1 + 16 * C, 1'b1, 1'b1);
        drain();
        check("R6 wrap to 0", int'(step_o), 0);

        // gapped enable
        for (int i = 0; i < 6 * C; i++) drive(1'(i % 2), 1'b1);

        // power off in mid-countdown: hold
        run(3, 1'b1, 1'b1);
        drain();
        begin
            int held;
            held = int'(step_o);
            run(3 * C, 1'b1, 1'b0);
            drain();
            check("R9 step held while off", int'(step_o), held);
            check("R9 no strobe while off", int'({len_stb_o, swp_stb_o, env_stb_o}), 0);
        end

        // power on restarts
        run(1, 1'b1, 1'b1);
        drain();
        check("R8 restart to step 0", int'(step_o), 0);

        // exact boundary: C-1 enabled cycles leaves step 0, one more moves it
        run(C - 1, 1'b1, 1'b1);
        drain();
        check("R2 before boundary", int'(step_o), 0);
        run(1, 1'b1, 1'b1);
        drain();
        check("R2 at boundary", int'(step_o), 1);
        check("R3 len on leaving 0", int'(len_stb_o), 1);

        // pseudo-random enable and power pattern
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            drive(lfsr[0] | lfsr[1], (lfsr[7:2] != 6'h00));
        end
        drain();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule